// File: doc/BRIEF.md
# HDLC receive frame filter

This block is the bit-level back end of a synchronous HDLC/SDLC receiver. It is fed with NRZ data that has already been recovered and decoded, one bit per cycle in which the receive clock enable is high. It looks for the opening flag and deletes the zeros that the transmitter stuffed into the data. It then assembles bytes least significant bit first and can filter each frame on the first byte of its address field. The surviving data bytes leave on a valid/ready stream, one byte per beat.

The final data byte of each frame carries status tags: end of frame, abort, short frame and CRC result. The two frame check bytes never appear as data. Because the last two bytes of a frame cannot be told apart from data until the closing flag arrives, the block holds back the three most recent bytes. A byte is released only when a newer byte proves that it is payload. The CRC is CRC-CCITT, preset to all ones and processed LSB first. A frame passes when the remainder left after the complemented check field equals the fixed residue 0xF0B8.

Top module: `hdlc_rx_filter`

## Requirements
- R1: After reset `out_valid` is 0 and the block is hunting. Every bit before the first flag is ignored and produces no beat.
- R2: The pattern 0,1,1,1,1,1,1,0 (in line order) is a flag. A single flag may close one frame and open the next, and a flag whose leading zero is the trailing zero of the previous flag is also recognised. Data bytes are assembled with the first received bit as bit 0.
- R3: A zero that follows five consecutive ones is deleted and is not part of any byte.
- R4: Of the bytes received between two flags, the last two are treated as the frame check field and are never delivered. The others are delivered in order, and only the last of them has `out_eof`=1.
- R5: On the end-of-frame beat of a frame closed by a flag, `out_crc_ok` is 1 exactly when the CRC-CCITT register (poly x^16+x^12+x^5+1, preset 0xFFFF, LSB first) over all received bytes, including the check field, equals 0xF0B8. On every other beat it is 0.
- R6: With `addr_mode`=00 no address filtering is done and every frame is delivered.
- R7: With any nonzero `addr_mode`, a frame is delivered only if its first byte equals `station_addr` or 0xFF. Otherwise no byte of the frame is delivered, and the block hunts for the next flag.
- R8: A frame with a single data byte is delivered. Its beat has `out_short`=1 when `addr_mode` is nonzero and `out_short`=0 when `addr_mode` is 00.
- R9: Seven consecutive ones inside a frame abort it. The oldest byte still held back is delivered with `out_eof`=1 and `out_abort`=1, the other held bytes are discarded, and the block hunts. If fewer than three bytes had been received, nothing is delivered.
- R10: The end-of-frame beat is valid in the clock cycle right after the enabled edge that samples the last zero of the closing flag.
- R11: A high `hunt_req` discards the frame in progress and makes the block hunt for a flag.
- R12: While `out_valid`=1 and `out_ready`=0, the beat is held unchanged. A byte produced while the beat is held is discarded.
- R13: Fewer than three bytes between two flags produce no beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | Receive clock enable, one received bit per high cycle |
| rx_bit | input | 1 | Decoded NRZ receive data |
| hunt_req | input | 1 | Abandon the current frame and hunt for a flag |
| addr_mode | input | 2 | 00 = accept all frames, nonzero = filter on first address byte |
| station_addr | input | 8 | Station address to match |
| out_ready | input | 1 | Downstream accepts the beat |
| out_valid | output | 1 | Beat present |
| out_data | output | 8 | Received data byte |
| out_eof | output | 1 | Last byte of the frame |
| out_abort | output | 1 | Frame ended by an abort |
| out_short | output | 1 | Frame ended before the control field |
| out_crc_ok | output | 1 | Check field matched the residue |

## Verification
The bench goes after the bytes at the edge of a frame. If the hold-back depth were wrong, a check byte would leak out as data or the last payload byte would be lost. If the flag detector needed a fresh zero, two frames joined by a shared zero would merge into one corrupt frame. Payloads full of ones test zero deletion: a receiver that kept the stuffed zero would shift every later bit. Further cases check that an aborted frame tags the right byte, that a rejected address suppresses the whole frame while a broadcast address passes, that a single-byte frame gets the short tag only when filtering is on, and that a stalled output keeps its byte and drops the later ones instead of overwriting it.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

   localparam int BYTE_W = 8;

   // One output beat: byte plus frame status tags
   typedef struct packed {
      logic [BYTE_W-1:0] data;
      logic              eof;
      logic              abort;
      logic              shrt;
      logic              crc_ok;
   } rx_beat_t;

endpackage

// File: rtl/hdlc_rx_linecls.sv
// Classifies each enabled line bit by the run of ones before it:
// flag, abort, deleted stuffing zero or ordinary data bit.
module hdlc_rx_linecls #(
   parameter int FLAG_RUN = 6
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_en,
   input  logic rx_bit,
   output logic ev_flag,
   output logic ev_abort,
   output logic ev_data
);
   localparam int RUN_W = $clog2(FLAG_RUN + 2);
   localparam logic [RUN_W-1:0] STUFF_AT = RUN_W'(FLAG_RUN - 1);
   localparam logic [RUN_W-1:0] FLAG_AT  = RUN_W'(FLAG_RUN);
   localparam logic [RUN_W-1:0] RUN_SAT  = RUN_W'(FLAG_RUN + 1);

   logic [RUN_W-1:0] run_q;

   always_comb begin
      ev_flag  = bit_en && !rx_bit && (run_q == FLAG_AT);
      ev_abort = bit_en &&  rx_bit && (run_q == FLAG_AT);
      if (rx_bit)
         ev_data = bit_en && (run_q != FLAG_AT) && (run_q != RUN_SAT);
      else
         ev_data = bit_en && (run_q != FLAG_AT) && (run_q != STUFF_AT);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         run_q <= '0;
      else if (bit_en) begin
         if (!rx_bit)
            run_q <= '0;
         else if (run_q != RUN_SAT)
            run_q <= run_q + 1'b1;
      end
   end

   // R3: a zero after exactly five ones never reaches the byte assembler
   assert_stuff_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_en && !rx_bit && run_q == STUFF_AT) |-> !ev_data && !ev_flag);

endmodule

// File: rtl/hdlc_rx_crc.sv
// Frame check register, advanced a whole byte per update.
module hdlc_rx_crc #(
   parameter int             W         = 16,
   parameter logic [W-1:0]   POLY      = 16'h8408,
   parameter logic [W-1:0]   INIT      = 16'hFFFF,
   parameter bit             LSB_FIRST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         upd,
   input  logic [7:0]   byte_in,
   output logic [W-1:0] crc_q
);
   logic [W-1:0] crc_nxt;

   generate
      if (LSB_FIRST) begin : g_reflected
         always_comb begin
            logic [W-1:0] c;
            logic         fb;
            c = crc_q;
            for (int k = 0; k < 8; k++) begin
               fb = c[0] ^ byte_in[k];
               c  = c >> 1;
               if (fb) c = c ^ POLY;
            end
            crc_nxt = c;
         end
      end else begin : g_direct
         always_comb begin
            logic [W-1:0] c;
            logic         fb;
            c = crc_q;
            for (int k = 0; k < 8; k++) begin
               fb = c[W-1] ^ byte_in[7-k];
               c  = c << 1;
               if (fb) c = c ^ POLY;
            end
            crc_nxt = c;
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc_q <= INIT;
      else if (clr) crc_q <= INIT;
      else if (upd) crc_q <= crc_nxt;
   end

   // R5: every frame starts its check from the preset value
   assert_crc_preset_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> crc_q == INIT);

endmodule

// File: rtl/hdlc_rx_outreg.sv
// Single output stage of the valid/ready stream.
module hdlc_rx_outreg
   import hdlc_rx_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     load,
   input  rx_beat_t beat_in,
   input  logic     ready,
   output logic     valid,
   output rx_beat_t beat_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid  <= 1'b0;
         beat_q <= '0;
      end else if (load && (!valid || ready)) begin
         valid  <= 1'b1;
         beat_q <= beat_in;
      end else if (ready) begin
         valid  <= 1'b0;
      end
   end

   // R12: a stalled beat stays put
   assert_hold_stable_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !ready) |=> valid && $stable(beat_q));

   // R9: an abort tag only ever comes with end of frame
   assert_abort_has_eof_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && beat_q.abort) |-> beat_q.eof);

   // R5: CRC result only on a normally closed frame
   assert_crc_on_close_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && beat_q.crc_ok) |-> beat_q.eof && !beat_q.abort);

   // R8: short status only on a normally closed frame
   assert_short_on_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && beat_q.shrt) |-> beat_q.eof && !beat_q.abort);

endmodule

// File: rtl/hdlc_rx_filter.sv
module hdlc_rx_filter
   import hdlc_rx_pkg::*;
#(
   parameter int                CRC_W       = 16,
   parameter logic [CRC_W-1:0]  CRC_POLY    = 16'h8408,
   parameter logic [CRC_W-1:0]  CRC_INIT    = 16'hFFFF,
   parameter logic [CRC_W-1:0]  CRC_RESIDUE = 16'hF0B8,
   parameter bit                CRC_LSB     = 1'b1,
   parameter int                FLAG_RUN    = 6,
   parameter logic [7:0]        BCAST_ADDR  = 8'hFF
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bit_en,
   input  logic       rx_bit,
   input  logic       hunt_req,
   input  logic [1:0] addr_mode,
   input  logic [7:0] station_addr,
   input  logic       out_ready,
   output logic       out_valid,
   output logic [7:0] out_data,
   output logic       out_eof,
   output logic       out_abort,
   output logic       out_short,
   output logic       out_crc_ok
);
   // Bytes held back: the check field plus the byte that may be last data
   localparam int HOLD    = CRC_W / 8 + 1;
   localparam int TOT_MAX = HOLD + 1;
   localparam int TOT_W   = $clog2(TOT_MAX + 1);
   localparam logic [TOT_W-1:0] HOLD_C = TOT_W'(HOLD);
   localparam logic [TOT_W-1:0] MAX_C  = TOT_W'(TOT_MAX);

   generate
      if (CRC_W % 8 != 0) begin : g_bad_crc_w
         $error("CRC_W must be a whole number of bytes");
      end
      if (FLAG_RUN < 3) begin : g_bad_flag_run
         $error("FLAG_RUN too small");
      end
   endgenerate

   logic ev_flag, ev_abort, ev_data;

   hdlc_rx_linecls #(.FLAG_RUN(FLAG_RUN)) u_linecls (
      .clk      (clk),
      .rst_n    (rst_n),
      .bit_en   (bit_en),
      .rx_bit   (rx_bit),
      .ev_flag  (ev_flag),
      .ev_abort (ev_abort),
      .ev_data  (ev_data)
   );

   logic             hunting_q;
   logic [7:0]       sh_q;
   logic [2:0]       bcnt_q;
   logic [TOT_W-1:0] tot_q;
   logic [7:0]       slot_q [HOLD];
   logic [CRC_W-1:0] crc_val;

   logic       byte_done, filt_on, addr_hit, reject, keep;
   logic       held_full, close_out, abort_out, push_out, emit;
   logic [7:0] new_byte;
   rx_beat_t   beat_nxt, beat_q;

   always_comb begin
      new_byte  = {rx_bit, sh_q[7:1]};
      byte_done = ev_data && !hunting_q && (bcnt_q == 3'd7);
      filt_on   = (addr_mode != 2'b00);
      addr_hit  = (new_byte == station_addr) || (new_byte == BCAST_ADDR);
      reject    = byte_done && (tot_q == '0) && filt_on && !addr_hit;
      keep      = byte_done && !reject;
      held_full = (tot_q >= HOLD_C);
      close_out = ev_flag  && !hunting_q && held_full;
      abort_out = ev_abort && !hunting_q && held_full;
      push_out  = keep && held_full;
      emit      = !hunt_req && (close_out || abort_out || push_out);

      beat_nxt.data   = slot_q[HOLD-1];
      beat_nxt.eof    = close_out || abort_out;
      beat_nxt.abort  = abort_out;
      beat_nxt.shrt   = close_out && filt_on && (tot_q == HOLD_C);
      beat_nxt.crc_ok = close_out && (crc_val == CRC_RESIDUE);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hunting_q <= 1'b1;
         sh_q      <= '0;
         bcnt_q    <= '0;
         tot_q     <= '0;
      end else if (hunt_req) begin
         hunting_q <= 1'b1;
         bcnt_q    <= '0;
         tot_q     <= '0;
      end else if (bit_en) begin
         if (ev_flag) begin
            hunting_q <= 1'b0;
            bcnt_q    <= '0;
            tot_q     <= '0;
         end else if (ev_abort) begin
            hunting_q <= 1'b1;
            bcnt_q    <= '0;
            tot_q     <= '0;
         end else if (ev_data && !hunting_q) begin
            sh_q   <= new_byte;
            bcnt_q <= bcnt_q + 3'd1;
            if (reject) begin
               hunting_q <= 1'b1;
               tot_q     <= '0;
            end else if (byte_done && tot_q != MAX_C) begin
               tot_q <= tot_q + 1'b1;
            end
         end
      end
   end

   // Hold-back line: newest byte enters slot 0, oldest leaves from the end
   generate
      for (genvar i = 0; i < HOLD; i++) begin : g_slot
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               slot_q[i] <= '0;
            else if (keep && !hunt_req) begin
               if (i == 0) slot_q[i] <= new_byte;
               else        slot_q[i] <= slot_q[(i == 0) ? 0 : i-1];
            end
         end
      end
   endgenerate

   hdlc_rx_crc #(
      .W         (CRC_W),
      .POLY      (CRC_POLY),
      .INIT      (CRC_INIT),
      .LSB_FIRST (CRC_LSB)
   ) u_crc (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (hunt_req || ev_flag),
      .upd     (keep),
      .byte_in (new_byte),
      .crc_q   (crc_val)
   );

   hdlc_rx_outreg u_outreg (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (emit),
      .beat_in (beat_nxt),
      .ready   (out_ready),
      .valid   (out_valid),
      .beat_q  (beat_q)
   );

   assign out_data   = beat_q.data;
   assign out_eof    = beat_q.eof;
   assign out_abort  = beat_q.abort;
   assign out_short  = beat_q.shrt;
   assign out_crc_ok = beat_q.crc_ok;

   // R9: an abort always leaves the block hunting
   assert_abort_hunts_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_abort |=> hunting_q);

   // R11: enter-hunt request empties the frame state
   assert_enter_hunt_R11: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_req |=> hunting_q && (tot_q == '0));

   // R7: a mismatching first byte drops the rest of the frame
   assert_reject_hunts_R7: assert property (@(posedge clk) disable iff (!rst_n)
      reject |=> hunting_q);

   // R2: a flag always leaves the block inside a frame, ready for data
   assert_flag_opens_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_flag && !hunt_req) |=> !hunting_q && (bcnt_q == 3'd0));

endmodule

// File: tb/hdlc_rx_filter_bench.sv
module hdlc_rx_filter_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_en = 1'b0;
   logic       rx_bit = 1'b1;
   logic       hunt_req = 1'b0;
   logic [1:0] addr_mode = 2'b00;
   logic [7:0] station_addr = 8'h00;
   logic       out_ready = 1'b1;
   logic       out_valid;
   logic [7:0] out_data;
   logic       out_eof, out_abort, out_short, out_crc_ok;

   always #10 clk = ~clk;

   hdlc_rx_filter u_hdlc_rx_filter (
      .clk          (clk),
      .rst_n        (rst_n),
      .bit_en       (bit_en),
      .rx_bit       (rx_bit),
      .hunt_req     (hunt_req),
      .addr_mode    (addr_mode),
      .station_addr (station_addr),
      .out_ready    (out_ready),
      .out_valid    (out_valid),
      .out_data     (out_data),
      .out_eof      (out_eof),
      .out_abort    (out_abort),
      .out_short    (out_short),
      .out_crc_ok   (out_crc_ok)
   );

   int n_chk = 0;
   int n_fail = 0;
   int run = 0;
   bit finished = 1'b0;

   // beat layout: {data, eof, abort, short, crc_ok}
   logic [11:0] cap [64];
   logic [11:0] expv [64];
   int n_cap = 0;
   int n_exp = 0;

   always @(negedge clk) begin
      if (rst_n && out_valid && out_ready && n_cap < 64) begin
         cap[n_cap] = {out_data, out_eof, out_abort, out_short, out_crc_ok};
         n_cap++;
      end
   end

   typedef struct packed {
      logic [1:0]  mode;
      logic [7:0]  sta;
      logic [3:0]  len;
      logic [47:0] bytes;
      logic        acc;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{2'd0, 8'h00, 4'd3, 48'h563412,       1'b1},
      '{2'd1, 8'h5A, 4'd3, 48'hC1035A,       1'b1},
      '{2'd1, 8'h5A, 4'd3, 48'hC1035B,       1'b0},
      '{2'd2, 8'h5A, 4'd2, 48'h13FF,         1'b1},
      '{2'd1, 8'h21, 4'd1, 48'h21,           1'b1},
      '{2'd0, 8'h00, 4'd1, 48'h77,           1'b1},
      '{2'd0, 8'h00, 4'd4, 48'hFC3F7EFF,     1'b1},
      '{2'd3, 8'h80, 4'd6, 48'hF8017EFF0080, 1'b1}
   };

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] crc_byte(logic [15:0] c, logic [7:0] b);
      logic [15:0] r;
      r = c;
      for (int k = 0; k < 8; k++) begin
         logic fb;
         fb = r[0] ^ b[k];
         r  = r >> 1;
         if (fb) r = r ^ 16'h8408;
      end
      return r;
   endfunction

   task automatic clear_log();
      n_cap = 0;
      n_exp = 0;
   endtask

   task automatic expect_beat(logic [7:0] d, bit e, bit a, bit s, bit c);
      expv[n_exp] = {d, e, a, s, c};
      n_exp++;
   endtask

   task automatic compare(string req);
      chk(n_cap == n_exp, req, "beat count", n_cap, n_exp);
      for (int i = 0; i < n_exp && i < n_cap; i++)
         chk(cap[i] == expv[i], req, "beat {data,eof,abort,short,crc}", cap[i], expv[i]);
   endtask

   task automatic send_bit(bit b);
      @(negedge clk);
      rx_bit = b;
      bit_en = 1'b1;
      @(negedge clk);
      bit_en = 1'b0;
   endtask

   task automatic send_raw(logic [7:0] b);
      for (int k = 0; k < 8; k++) send_bit(b[k]);
   endtask

   task automatic send_flag();
      send_raw(8'h7E);
      run = 0;
   endtask

   task automatic send_stuffed(logic [7:0] b);
      for (int k = 0; k < 8; k++) begin
         send_bit(b[k]);
         if (b[k]) begin
            run++;
            if (run == 5) begin
               send_bit(1'b0);
               run = 0;
            end
         end else begin
            run = 0;
         end
      end
   endtask

   task automatic send_body(logic [47:0] bytes, int len, bit bad);
      logic [15:0] c;
      c = 16'hFFFF;
      for (int i = 0; i < len; i++) begin
         send_stuffed(bytes[8*i +: 8]);
         c = crc_byte(c, bytes[8*i +: 8]);
      end
      c = ~c;
      if (bad) c = c ^ 16'h0001;
      send_stuffed(c[7:0]);
      send_stuffed(c[15:8]);
   endtask

   task automatic send_frame(logic [47:0] bytes, int len, bit bad);
      send_flag();
      send_body(bytes, len, bad);
      send_flag();
   endtask

   task automatic expect_frame(logic [47:0] bytes, int len, bit sh, bit crc);
      for (int i = 0; i < len; i++)
         expect_beat(bytes[8*i +: 8], i == len-1, 1'b0, sh && i == len-1, crc && i == len-1);
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual running expected done");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1: reset state, then line noise without a flag is ignored
      chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
      clear_log();
      send_raw(8'hA5);
      send_raw(8'h3C);
      send_raw(8'h5A);
      send_raw(8'hFF);
      idle(4);
      compare("R1");

      // Table walk: R4 delivery, R5 good CRC, R6/R7 address modes, R8 short, R3 stuffing
      for (int v = 0; v < 8; v++) begin
         string tag;
         addr_mode    = VECS[v].mode;
         station_addr = VECS[v].sta;
         clear_log();
         if (VECS[v].acc)
            expect_frame(VECS[v].bytes, int'(VECS[v].len),
                         (VECS[v].mode != 2'd0) && (VECS[v].len == 4'd1), 1'b1);
         send_frame(VECS[v].bytes, int'(VECS[v].len), 1'b0);
         idle(4);
         if (!VECS[v].acc)                 tag = "R7";
         else if (VECS[v].len == 4'd1)     tag = "R8";
         else if (v >= 6)                  tag = "R3";
         else if (VECS[v].mode == 2'd0)    tag = "R6";
         else                              tag = "R4";
         compare(tag);
      end
      addr_mode = 2'b00;

      // R2: one flag closes frame A and opens frame B
      clear_log();
      expect_frame(48'h332211, 3, 1'b0, 1'b1);
      expect_frame(48'h66554433, 4, 1'b0, 1'b1);
      send_flag();
      send_body(48'h332211, 3, 1'b0);
      send_flag();
      send_body(48'h66554433, 4, 1'b0);
      send_flag();
      idle(4);
      compare("R2");

      // R2: closing flag and next opening flag share one zero
      clear_log();
      expect_frame(48'hC3B2A1, 3, 1'b0, 1'b1);
      expect_frame(48'h0F0E0D, 3, 1'b0, 1'b1);
      send_flag();
      send_body(48'hC3B2A1, 3, 1'b0);
      send_flag();
      for (int k = 0; k < 6; k++) send_bit(1'b1);
      send_bit(1'b0);
      run = 0;
      send_body(48'h0F0E0D, 3, 1'b0);
      send_flag();
      idle(4);
      compare("R2");

      // R5: corrupted check field
      clear_log();
      expect_frame(48'h9C8B7A, 3, 1'b0, 1'b0);
      send_frame(48'h9C8B7A, 3, 1'b1);
      idle(4);
      compare("R5");

      // R10: end-of-frame beat right after the last flag bit
      clear_log();
      send_flag();
      send_body(48'h4D3C2B, 3, 1'b0);
      send_flag();
      chk(out_valid == 1'b1 && out_eof == 1'b1, "R10", "eof beat timing",
          {out_valid, out_eof}, 2'b11);
      chk(out_data == 8'h4D, "R10", "eof beat data", out_data, 8'h4D);
      idle(4);

      // R9: abort after five bytes
      clear_log();
      expect_beat(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
      expect_beat(8'h22, 1'b0, 1'b0, 1'b0, 1'b0);
      expect_beat(8'h33, 1'b1, 1'b1, 1'b0, 1'b0);
      send_flag();
      send_stuffed(8'h11);
      send_stuffed(8'h22);
      send_stuffed(8'h33);
      send_stuffed(8'h44);
      send_stuffed(8'h35);
      for (int k = 0; k < 7; k++) send_bit(1'b1);
      send_raw(8'hFF);
      idle(4);
      compare("R9");

      // R9: abort with only two bytes received delivers nothing
      clear_log();
      send_flag();
      send_stuffed(8'h11);
      send_stuffed(8'h22);
      for (int k = 0; k < 7; k++) send_bit(1'b1);
      send_raw(8'hFF);
      idle(4);
      compare("R9");

      // R13: runt frames and back-to-back flags
      clear_log();
      send_flag();
      send_flag();
      send_stuffed(8'h55);
      send_stuffed(8'h66);
      send_flag();
      idle(4);
      compare("R13");

      // R11: enter hunt in mid-frame
      clear_log();
      expect_beat(8'h11, 1'b0, 1'b0, 1'b0, 1'b0);
      expect_frame(48'hA3A2A1, 3, 1'b0, 1'b1);
      send_flag();
      send_stuffed(8'h11);
      send_stuffed(8'h22);
      send_stuffed(8'h33);
      send_stuffed(8'h44);
      @(negedge clk);
      hunt_req = 1'b1;
      @(negedge clk);
      hunt_req = 1'b0;
      send_stuffed(8'h55);
      send_stuffed(8'h66);
      send_flag();
      send_frame(48'hA3A2A1, 3, 1'b0);
      idle(4);
      compare("R11");

      // R12: stalled output keeps the first byte, later bytes dropped
      clear_log();
      out_ready = 1'b0;
      send_frame(48'hD3D2D1, 3, 1'b0);
      idle(2);
      chk(out_valid == 1'b1, "R12", "valid while stalled", out_valid, 1);
      chk({out_data, out_eof} == {8'hD1, 1'b0}, "R12", "held beat",
          {out_data, out_eof}, {8'hD1, 1'b0});
      idle(10);
      chk({out_valid, out_data} == {1'b1, 8'hD1}, "R12", "held beat later",
          {out_valid, out_data}, {1'b1, 8'hD1});
      @(posedge clk);
      #2 out_ready = 1'b1;
      expect_beat(8'hD1, 1'b0, 1'b0, 1'b0, 1'b0);
      idle(4);
      compare("R12");
      chk(out_valid == 1'b0, "R12", "valid after accept", out_valid, 0);

      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule